// File: doc/BRIEF.md
# Two-Stage Four-Value Descending Sorter

The block takes a set of four unsigned bytes and returns them in descending order one clock later. The input set is packed into a single bus of four lanes. The result comes back on a bus with the same layout, and output lane 0 holds the largest value.

The work is split across one pipeline register. Before the register, every pair of inputs is compared at the same moment, straight from the input pins. The six comparison bits are stored together with a copy of the raw values. After the register, each value's rank is counted from the stored bits. That count becomes a lane select code, and each output lane is a 4:1 multiplexer over the stored values.

Equal values are ordered by lane index: the lower-indexed lane wins a tie. This makes the ranks a true permutation, so repeated values come out intact. A new set may be presented on every clock.

The stream has no ready signal, so there is no back-pressure. Every cycle in which `out_valid` is high carries a result that the consumer must take in that same cycle. The producer may therefore assert `in_valid` at any time.

Top module: `sort4_rank_pipe`

## Requirements
- R1: Whenever `out_valid` is high, the output lanes are non-increasing. Lane k occupies bits [8k+7:8k], and lane 0 holds the largest value.
- R2: Whenever `out_valid` is high, the output lanes are a permutation of the input lanes sampled on the previous clock edge. Each value appears as many times as it did at the input.
- R3: The latency is exactly one clock. The largest input value sampled at a rising edge appears on output lane 0 directly after that edge.
- R4: `out_valid` equals `in_valid` as sampled on the previous rising edge. A new input set is accepted on every consecutive clock.
- R5: A synchronous active-high `rst` drives `out_valid` to 0 and every output lane to 0 after the edge at which it is sampled.
- R6: When two or more input lanes are equal, each of those lanes' values still appears on its own output lane. No output lane is left empty and no two values are merged, including the case where all four lanes are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input set is present this cycle |
| in_vals | input | 32 | Four unsigned 8-bit lanes, lane k at bits [8k+7:8k] |
| out_valid | output | 1 | Sorted set is present this cycle |
| out_vals | output | 32 | Sorted lanes, lane 0 largest, lane 3 smallest |

## Verification
The bench concentrates on sets with repeated values: all four lanes equal, two pairs of equals, and three equal with one outlier. A plain strict greater-than rank would give tied lanes the same rank, so one output lane would go to zero and another would show the OR of two values. Sets ordered ascending and descending check that no lane is passed through in its input position. Bursts of back-to-back valid sets with random gaps, plus a reset asserted in mid-stream, expose a valid flag or data path that is off by one cycle, or a reset that leaves stale data on the outputs.

// File: rtl/sort4_pkg.sv
package sort4_pkg;

  // number of unordered pairs among n lanes
  function automatic int num_pairs(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  // flat position of the comparison bit for lanes lo < hi
  function automatic int pair_idx(input int n, input int lo, input int hi);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/sort4_cmp_stage.sv
module sort4_cmp_stage #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int P = sort4_pkg::num_pairs(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_vals,
  output logic           q_valid,
  output logic [N*W-1:0] q_vals,
  output logic [P-1:0]   q_ge
);

  logic [P-1:0] ge_now;

  // one layer of parallel comparators, all fed from the raw lanes
  for (genvar lo = 0; lo < N; lo++) begin : g_lo
    for (genvar hi = lo + 1; hi < N; hi++) begin : g_hi
      localparam int PI = sort4_pkg::pair_idx(N, lo, hi);
      // lower lane index wins a tie
      assign ge_now[PI] = (in_vals[lo*W +: W] >= in_vals[hi*W +: W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_vals  <= '0;
      q_ge    <= '0;
    end else begin
      q_valid <= in_valid;
      q_vals  <= in_vals;
      q_ge    <= ge_now;
    end
  end

endmodule

// File: rtl/sort4_rank_decode.sv
module sort4_rank_decode #(
  parameter int N = 4,
  localparam int P  = sort4_pkg::num_pairs(N),
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [P-1:0]         ge,
  output logic [N-1:0][RW-1:0] sel
);

  logic [N-1:0][RW-1:0] rank;

  // rank of a lane = how many other lanes it beats
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j > i)
          rank[i] = rank[i] + RW'(ge[sort4_pkg::pair_idx(N, i, j)]);
        else if (j < i)
          rank[i] = rank[i] + RW'(!ge[sort4_pkg::pair_idx(N, j, i)]);
      end
    end
  end

  // output lane p takes the lane whose rank is N-1-p
  always_comb begin
    for (int p = 0; p < N; p++) begin
      sel[p] = '0;
      for (int i = 0; i < N; i++) begin
        if (rank[i] == RW'(N - 1 - p)) sel[p] = RW'(i);
      end
    end
  end

endmodule

// File: rtl/sort4_lane_mux.sv
module sort4_lane_mux #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][RW-1:0] sel,
  input  logic [N*W-1:0]       vals,
  output logic [N*W-1:0]       sorted
);

  for (genvar p = 0; p < N; p++) begin : g_lane
    always_comb begin
      sorted[p*W +: W] = '0;
      for (int i = 0; i < N; i++) begin
        if (sel[p] == RW'(i)) sorted[p*W +: W] = vals[i*W +: W];
      end
    end
  end

endmodule

// File: rtl/sort4_rank_pipe.sv
module sort4_rank_pipe #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_vals,
  output logic           out_valid,
  output logic [N*W-1:0] out_vals
);

  localparam int P  = sort4_pkg::num_pairs(N);
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  logic [N*W-1:0]       q_vals;
  logic [P-1:0]         q_ge;
  logic [N-1:0][RW-1:0] sel;

  sort4_cmp_stage #(.N(N), .W(W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_vals  (in_vals),
    .q_valid  (out_valid),
    .q_vals   (q_vals),
    .q_ge     (q_ge)
  );

  sort4_rank_decode #(.N(N)) u_rank (
    .ge  (q_ge),
    .sel (sel)
  );

  sort4_lane_mux #(.N(N), .W(W)) u_mux (
    .sel    (sel),
    .vals   (q_vals),
    .sorted (out_vals)
  );

endmodule

// File: rtl/sort4_rank_pipe_chk.sv
module sort4_rank_pipe_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N*W-1:0] in_vals,
  input logic           out_valid,
  input logic [N*W-1:0] out_vals
);

  localparam int SW = W + $clog2(N) + 1;

  logic [SW-1:0] in_sum, out_sum;
  logic [W-1:0]  in_xor, out_xor, in_max;
  logic          in_all_eq, out_desc, out_all_lane0;

  always_comb begin
    in_sum = '0; out_sum = '0; in_xor = '0; out_xor = '0;
    in_max = '0; in_all_eq = 1'b1; out_desc = 1'b1; out_all_lane0 = 1'b1;
    for (int k = 0; k < N; k++) begin
      in_sum  = in_sum + SW'(in_vals[k*W +: W]);
      out_sum = out_sum + SW'(out_vals[k*W +: W]);
      in_xor  = in_xor ^ in_vals[k*W +: W];
      out_xor = out_xor ^ out_vals[k*W +: W];
      if (in_vals[k*W +: W] > in_max) in_max = in_vals[k*W +: W];
      if (in_vals[k*W +: W] != in_vals[W-1:0]) in_all_eq = 1'b0;
      if (out_vals[k*W +: W] != out_vals[W-1:0]) out_all_lane0 = 1'b0;
      if (k > 0 && out_vals[k*W +: W] > out_vals[(k-1)*W +: W]) out_desc = 1'b0;
    end
  end

  assert_desc_order_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_desc);

  assert_perm_sum_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum == $past(in_sum) && out_xor == $past(in_xor)));

  assert_max_lead_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_vals[W-1:0] == $past(in_max)));

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vals == '0));

  assert_ties_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_all_eq) |=> (out_all_lane0 && out_vals[W-1:0] == $past(in_vals[W-1:0])));

endmodule

bind sort4_rank_pipe sort4_rank_pipe_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/sort4_rank_pipe_test.sv
module sort4_rank_pipe_test;

  localparam int N = 4;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_vals = '0;
  logic           out_valid;
  logic [N*W-1:0] out_vals;

  int checks = 0;
  int errors = 0;

  logic           exp_valid = 1'b0;
  logic [N*W-1:0] exp_vals = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sort4_rank_pipe #(.N(N), .W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vals(in_vals),
    .out_valid(out_valid), .out_vals(out_vals)
  );

  // behavioural reference: selection sort into descending lanes
  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    int a[N];
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) a[k] = int'(v[k*W +: W]);
    for (int k = 0; k < N; k++)
      for (int m = k + 1; m < N; m++)
        if (a[m] > a[k]) begin int t; t = a[k]; a[k] = a[m]; a[m] = t; end
    r = '0;
    for (int k = 0; k < N; k++) r[k*W +: W] = W'(a[k]);
    return r;
  endfunction

  task automatic check_outputs(input string tag);
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s R4 out_valid=%0b expected %0b", tag, out_valid, exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (out_vals !== exp_vals) begin
        errors++;
        $display("FAIL %s R1/R2/R3/R6 out_vals=%h expected %h", tag, out_vals, exp_vals);
      end
    end
  endtask

  // called at a falling edge: check the last set, then present the next
  task automatic step(input logic v, input logic [N*W-1:0] d, input string tag);
    check_outputs(tag);
    in_valid = v;
    in_vals  = d;
    exp_valid = v;
    exp_vals  = ref_sort(d);
    @(negedge clk);
  endtask

  function automatic logic [N*W-1:0] pack4(input int a, input int b, input int c, input int d);
    return {W'(d), W'(c), W'(b), W'(a)};
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < MAX_CYCLES) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    checks++;
    if (out_valid !== 1'b0 || out_vals !== '0) begin
      errors++;
      $display("FAIL R5 reset out_valid=%0b out_vals=%h expected 0 0", out_valid, out_vals);
    end
    rst = 1'b0;
    exp_valid = 1'b0;
    @(negedge clk);

    // R1/R3 distinct, ascending then descending lane order
    step(1'b1, pack4(1, 2, 3, 4), "asc R1");
    step(1'b1, pack4(200, 100, 50, 9), "desc R1");
    step(1'b1, pack4(9, 255, 0, 128), "mixed R3");
    // R6: ties
    step(1'b1, pack4(8'h55, 8'h55, 8'h55, 8'h55), "all-equal R6");
    step(1'b1, pack4(0, 0, 0, 0), "all-zero R6");
    step(1'b1, pack4(255, 255, 255, 255), "all-ones R6");
    step(1'b1, pack4(7, 3, 7, 3), "two-pairs R6");
    step(1'b1, pack4(6, 6, 1, 6), "three-equal R6");
    step(1'b1, pack4(3, 12, 12, 5), "one-pair R6");
    // R4: gap in valid
    step(1'b0, pack4(1, 1, 1, 1), "gap R4");
    step(1'b1, pack4(0, 255, 0, 255), "after-gap R2");

    // R2/R4: random stream, narrow and full ranges, random gaps
    for (int n = 0; n < 2000; n++) begin
      logic [N*W-1:0] d;
      for (int k = 0; k < N; k++)
        d[k*W +: W] = (n % 2 == 0) ? W'($urandom_range(0, 3)) : W'($urandom_range(0, 255));
      step(($urandom_range(0, 3) != 0), d, "random R2");
    end

    // R5: reset in mid-stream
    check_outputs("pre-reset R4");
    rst = 1'b1;
    in_valid = 1'b1;
    in_vals = pack4(10, 20, 30, 40);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_vals !== '0) begin
      errors++;
      $display("FAIL R5 mid reset out_valid=%0b out_vals=%h expected 0 0", out_valid, out_vals);
    end
    rst = 1'b0;
    exp_valid = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    step(1'b1, pack4(44, 2, 44, 90), "post-reset R1");
    step(1'b0, '0, "tail R3");
    check_outputs("final R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule